// File: doc/BRIEF.md
# E1 Receive Spare and International Bit Extractor

This block sits behind an E1 receive framer that has already found frame alignment. For each received bit the framer gives a one-cycle strobe. With the strobe come a flag for timeslot 0, the bit position inside that timeslot, and a flag that tells align frames from non-align frames. The block copies every received bit to a serial link data output. It also produces a link clock that pulses only on the spare (Sa) bit positions a five-bit mask selects, so downstream logic can capture just those bits. A frame-sync pulse marks the international (Si) bit of each frame.

The block collects the timeslot-0 byte of an align frame and the timeslot-0 byte of the following non-align frame. When the non-align byte is complete, both bytes go into host-readable registers in the same clock edge that sets a sticky status flag. The host then has one double-frame (250 us at 2.048 Mb/s) to read both bytes before the next pair replaces them. The host clears the flag with a write-one strobe.

Top module: `sasi_rx_extract`

## Requirements
- R1: A synchronous active-high reset drives every output to zero: link data, link clock, frame sync, both capture registers and the status flag.
- R2: One cycle after each strobe, `link_data` equals the bit that was strobed, for every timeslot and not only timeslot 0. Between strobes it holds that value.
- R3: `link_clk` pulses for one cycle, one cycle after a strobe, only when the strobe is in timeslot 0 of a non-align frame at positions 3 to 7 and the matching mask bit is set. Mask bit 0 selects Sa4 at position 3, and so on up to mask bit 4, which selects Sa8 at position 7. Every mask combination is accepted.
- R4: `fsync` pulses for one cycle, one cycle after the timeslot-0 strobe at position 0 (the Si bit) of every frame, align or non-align. It never pulses at any other time.
- R5: `align_byte` takes the align frame's timeslot-0 bits with position 0 in bit 7 down to position 7 in bit 0. On a correctly aligned line this reads Si followed by 0011011.
- R6: `nonalign_byte` uses the same position-to-bit mapping for the non-align frame's timeslot 0. It is written together with `align_byte`, one cycle after the non-align position-7 strobe, if an align-frame position-7 strobe has arrived since the last update.
- R7: `align_flag` rises in the same cycle the capture registers change and stays set until `flag_clr` is pulsed. A clear takes effect one cycle later. A set and a clear in the same cycle leave the flag set.
- R8: Between updates both capture registers hold their value. A non-align frame with no align frame before it since the last update does not update them. Bits outside timeslot 0 never change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe marking a received bit |
| rx_bit | input | 1 | Received data bit, valid with `bit_en` |
| in_ts0 | input | 1 | Current bit belongs to timeslot 0 |
| bit_pos | input | 3 | Bit position in the timeslot, 0 = first received (MSB) |
| align_frame | input | 1 | 1 = align frame, 0 = non-align frame |
| sa_mask | input | 5 | Link clock enables, bit 0 = Sa4 through bit 4 = Sa8 |
| flag_clr | input | 1 | Write-one-to-clear strobe for the status flag |
| link_data | output | 1 | Serial copy of every received bit |
| link_clk | output | 1 | Pulse on each selected Sa bit |
| fsync | output | 1 | Pulse on the Si bit of each frame |
| align_byte | output | 8 | Captured align-frame timeslot-0 byte |
| nonalign_byte | output | 8 | Captured non-align-frame timeslot-0 byte |
| align_flag | output | 1 | Sticky flag, set when both bytes are updated |

## Verification
The link clock is driven with an all-zero mask, an all-one mask, an alternating mask and random masks. This shows whether the gate decodes each Sa position on its own and whether it keeps align-frame bits and non-Sa positions out. Random non-align bytes combined with the fixed alignment pattern show whether the position-to-bit mapping is reversed or shifted in either register. A non-align frame sent without an align frame first, and random filler timeslots, show whether the update condition is too loose. Clears placed on the update strobe itself, on other strobes and in idle cycles separate set-over-clear priority from plain clearing.

// File: rtl/sasi_pkg.sv
package sasi_pkg;

    parameter int TS_BITS  = 8;
    parameter int SA_COUNT = 5;
    parameter int SA_FIRST = 3;
    localparam int POS_W   = $clog2(TS_BITS);

    typedef logic [POS_W-1:0] pos_t;

    // per-strobe decode of where the current bit sits in the double-frame
    typedef struct packed {
        logic ts0_hit;     // strobe inside timeslot 0
        logic si_hit;      // strobe on the Si position
        logic sa_gate;     // strobe on a selected Sa position of a non-align frame
        logic align_hit;   // strobe inside timeslot 0 of an align frame
        logic align_end;   // last timeslot-0 bit of an align frame
        logic nalign_end;  // last timeslot-0 bit of a non-align frame
    } slot_info_t;

    function automatic logic sa_pick(input pos_t pos, input logic [SA_COUNT-1:0] mask);
        int idx;
        idx = int'(pos) - SA_FIRST;
        if (idx >= 0 && idx < SA_COUNT) return mask[idx];
        return 1'b0;
    endfunction

endpackage

// File: rtl/sasi_pos_decode.sv
module sasi_pos_decode
    import sasi_pkg::*;
#(
    parameter int BYTE_W = TS_BITS,
    parameter int MASK_W = SA_COUNT
) (
    input  logic              bit_en,
    input  logic              in_ts0,
    input  pos_t              bit_pos,
    input  logic              align_frame,
    input  logic [MASK_W-1:0] sa_mask,
    output slot_info_t        info
);
    localparam pos_t LAST_POS = pos_t'(BYTE_W - 1);

    logic ts0_strobe;
    assign ts0_strobe = bit_en && in_ts0;

    always_comb begin
        info            = '0;
        info.ts0_hit    = ts0_strobe;
        info.si_hit     = ts0_strobe && (bit_pos == '0);
        info.sa_gate    = ts0_strobe && !align_frame && sa_pick(bit_pos, sa_mask);
        info.align_hit  = ts0_strobe && align_frame;
        info.align_end  = ts0_strobe && align_frame && (bit_pos == LAST_POS);
        info.nalign_end = ts0_strobe && !align_frame && (bit_pos == LAST_POS);
    end
endmodule

// File: rtl/sasi_capture.sv
module sasi_capture
    import sasi_pkg::*;
#(
    parameter int BYTE_W = TS_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_info_t        info,
    input  pos_t              bit_pos,
    input  logic              rx_bit,
    output logic              commit,
    output logic [BYTE_W-1:0] align_q,
    output logic [BYTE_W-1:0] nalign_q
);
    logic [BYTE_W-1:0] align_sh, nalign_sh, nalign_next;
    logic              align_seen;
    int                slot_idx;

    // position 0 is the MSB, the last position lands in bit 0
    always_comb begin
        slot_idx    = BYTE_W - 1 - int'(bit_pos);
        nalign_next = nalign_sh;
        if (info.ts0_hit && !info.align_hit)
            nalign_next[slot_idx] = rx_bit;
    end

    assign commit = info.nalign_end && align_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            align_sh   <= '0;
            nalign_sh  <= '0;
            align_seen <= 1'b0;
            align_q    <= '0;
            nalign_q   <= '0;
        end else begin
            nalign_sh <= nalign_next;
            if (info.align_hit)
                align_sh[slot_idx] <= rx_bit;
            if (commit) begin
                align_q    <= align_sh;
                nalign_q   <= nalign_next;
                align_seen <= 1'b0;
            end else if (info.align_end) begin
                align_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sasi_link_out.sv
module sasi_link_out
    import sasi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       rx_bit,
    input  slot_info_t info,
    output logic       link_data,
    output logic       link_clk,
    output logic       fsync
);
    always_ff @(posedge clk) begin
        if (rst) begin
            link_data <= 1'b0;
            link_clk  <= 1'b0;
            fsync     <= 1'b0;
        end else begin
            if (bit_en)
                link_data <= rx_bit;
            link_clk <= info.sa_gate;
            fsync    <= info.si_hit;
        end
    end
endmodule

// File: rtl/sasi_flag.sv
module sasi_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/sasi_rx_extract.sv
module sasi_rx_extract
    import sasi_pkg::*;
#(
    parameter int BYTE_W = TS_BITS,
    parameter int MASK_W = SA_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              in_ts0,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              align_frame,
    input  logic [MASK_W-1:0] sa_mask,
    input  logic              flag_clr,
    output logic              link_data,
    output logic              link_clk,
    output logic              fsync,
    output logic [BYTE_W-1:0] align_byte,
    output logic [BYTE_W-1:0] nonalign_byte,
    output logic              align_flag
);
    slot_info_t info;
    logic       commit;

    sasi_pos_decode #(.BYTE_W(BYTE_W), .MASK_W(MASK_W)) u_dec (
        .bit_en(bit_en), .in_ts0(in_ts0), .bit_pos(bit_pos),
        .align_frame(align_frame), .sa_mask(sa_mask), .info(info)
    );

    sasi_capture #(.BYTE_W(BYTE_W)) u_cap (
        .clk(clk), .rst(rst), .info(info), .bit_pos(bit_pos), .rx_bit(rx_bit),
        .commit(commit), .align_q(align_byte), .nalign_q(nonalign_byte)
    );

    sasi_link_out u_link (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .info(info),
        .link_data(link_data), .link_clk(link_clk), .fsync(fsync)
    );

    sasi_flag u_flag (
        .clk(clk), .rst(rst), .set_i(commit), .clr_i(flag_clr), .flag_o(align_flag)
    );
endmodule

// File: rtl/sasi_rx_extract_chk.sv
module sasi_rx_extract_chk #(
    parameter int BYTE_W   = 8,
    parameter int MASK_W   = 5,
    parameter int POS_W    = 3,
    parameter int SA_FIRST = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_en,
    input logic              rx_bit,
    input logic              in_ts0,
    input logic [POS_W-1:0]  bit_pos,
    input logic              align_frame,
    input logic              flag_clr,
    input logic              link_data,
    input logic              link_clk,
    input logic              fsync,
    input logic [BYTE_W-1:0] align_byte,
    input logic [BYTE_W-1:0] nonalign_byte,
    input logic              align_flag
);
    logic na_last;
    assign na_last = bit_en && in_ts0 && !align_frame && (int'(bit_pos) == BYTE_W - 1);

    // R2
    a_r2_link_follows: assert property (@(posedge clk) disable iff (rst)
        $past(bit_en) |-> link_data == $past(rx_bit));
    // R3
    a_r3_clk_in_sa_only: assert property (@(posedge clk) disable iff (rst)
        link_clk |-> $past(bit_en && in_ts0 && !align_frame && int'(bit_pos) >= SA_FIRST));
    // R4
    a_r4_fsync_on_si: assert property (@(posedge clk) disable iff (rst)
        fsync |-> $past(bit_en && in_ts0 && bit_pos == '0));
    // R7
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        $rose(align_flag) |-> $past(na_last));
    a_r7_clear_works: assert property (@(posedge clk) disable iff (rst)
        $past(flag_clr && !na_last) |-> !align_flag);
    // R8
    a_r8_align_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(na_last) |-> $stable(align_byte));
    a_r8_nalign_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(na_last) |-> $stable(nonalign_byte));
endmodule

bind sasi_rx_extract sasi_rx_extract_chk #(
    .BYTE_W(BYTE_W), .MASK_W(MASK_W), .POS_W(sasi_pkg::POS_W), .SA_FIRST(sasi_pkg::SA_FIRST)
) u_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .in_ts0(in_ts0),
    .bit_pos(bit_pos), .align_frame(align_frame), .flag_clr(flag_clr),
    .link_data(link_data), .link_clk(link_clk), .fsync(fsync),
    .align_byte(align_byte), .nonalign_byte(nonalign_byte), .align_flag(align_flag)
);

// File: tb/sim_sasi_rx_extract.sv
`timescale 1ns/1ps
module sim_sasi_rx_extract;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0, rx_bit = 1'b0, in_ts0 = 1'b0, align_frame = 1'b0, flag_clr = 1'b0;
    logic [2:0] bit_pos = '0;
    logic [4:0] sa_mask = '0;
    logic       link_data, link_clk, fsync, align_flag;
    logic [7:0] align_byte, nonalign_byte;

    int n_cmp = 0, n_bad = 0;
    logic done = 1'b0;

    // bench model state
    logic [7:0] m_al_sh = '0, m_na_sh = '0, m_al = '0, m_na = '0;
    logic       m_seen = 1'b0, m_flag = 1'b0;

    always #2 clk = ~clk;

    sasi_rx_extract u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .in_ts0(in_ts0),
        .bit_pos(bit_pos), .align_frame(align_frame), .sa_mask(sa_mask), .flag_clr(flag_clr),
        .link_data(link_data), .link_clk(link_clk), .fsync(fsync),
        .align_byte(align_byte), .nonalign_byte(nonalign_byte), .align_flag(align_flag)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic exp_clk(input logic t0, input logic [2:0] p, input logic al,
                                     input logic [4:0] m);
        if (!t0 || al || p < 3) return 1'b0;
        return m[p - 3];
    endfunction

    task automatic check_regs();
        chk("R5 align_byte", {24'd0, align_byte}, {24'd0, m_al});
        chk("R6 nonalign_byte", {24'd0, nonalign_byte}, {24'd0, m_na});
        chk("R7 align_flag", {31'd0, align_flag}, {31'd0, m_flag});
    endtask

    task automatic send_bit(input logic b, input logic t0, input logic [2:0] p,
                            input logic al, input logic clr);
        logic commit;
        @(negedge clk);
        rx_bit = b; in_ts0 = t0; bit_pos = p; align_frame = al; bit_en = 1'b1; flag_clr = clr;
        commit = t0 && !al && (p == 3'd7) && m_seen;
        if (t0 && al)  m_al_sh[7 - p] = b;
        if (t0 && !al) m_na_sh[7 - p] = b;
        if (commit) begin
            m_al = m_al_sh; m_na = m_na_sh; m_seen = 1'b0; m_flag = 1'b1;
        end else begin
            if (t0 && al && p == 3'd7) m_seen = 1'b1;
            if (clr) m_flag = 1'b0;
        end
        @(negedge clk);
        bit_en = 1'b0; flag_clr = 1'b0;
        chk("R2 link_data", {31'd0, link_data}, {31'd0, b});
        chk("R3 link_clk", {31'd0, link_clk}, {31'd0, exp_clk(t0, p, al, sa_mask)});
        chk("R4 fsync", {31'd0, fsync}, {31'd0, (t0 && p == 3'd0)});
        check_regs();
    endtask

    // clrpos 8 means no clear during this frame
    task automatic send_frame(input logic al, input logic [7:0] ts0, input int nslots, input int clrpos);
        for (int p = 0; p < 8; p++)
            send_bit(ts0[7 - p], 1'b1, 3'(p), al, (p == clrpos));
        for (int k = 0; k < nslots * 8; k++)
            send_bit(1'($urandom), 1'b0, 3'($urandom), al, 1'b0);
    endtask

    task automatic idle_clear();
        @(negedge clk);
        flag_clr = 1'b1;
        m_flag = 1'b0;
        @(negedge clk);
        flag_clr = 1'b0;
        check_regs();
        chk("R2 link_data hold", {31'd0, link_data}, {31'd0, rx_bit});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 link_data", {31'd0, link_data}, 32'd0);
        chk("R1 link_clk", {31'd0, link_clk}, 32'd0);
        chk("R1 fsync", {31'd0, fsync}, 32'd0);
        chk("R1 bytes", {16'd0, align_byte, nonalign_byte}, 32'd0);
        chk("R1 flag", {31'd0, align_flag}, 32'd0);

        // R8: non-align frame without a preceding align frame must not update
        sa_mask = 5'h1f;
        send_frame(1'b0, 8'hDF, 2, 8);
        send_frame(1'b0, 8'h5A, 1, 8);

        // directed masks, then random ones
        for (int f = 0; f < 30; f++) begin
            logic [7:0] nab;
            int cp;
            case (f)
                0: sa_mask = 5'h00;
                1: sa_mask = 5'h1f;
                2: sa_mask = 5'h15;
                3: sa_mask = 5'h0a;
                default: sa_mask = 5'($urandom);
            endcase
            nab = {1'($urandom), 1'b1, 1'($urandom), 5'($urandom)};
            send_frame(1'b1, {1'($urandom), 7'b0011011}, 2, 8);
            // R7: some frames clear on the update strobe itself (set wins), others earlier
            cp = (f % 3 == 0) ? 7 : ((f % 3 == 1) ? int'($urandom_range(0, 6)) : 8);
            send_frame(1'b0, nab, 2, cp);
            if (f % 4 == 2) idle_clear();
        end

        // R8: an align frame followed by another align frame, then non-align
        send_frame(1'b1, 8'h1B, 1, 8);
        send_frame(1'b1, 8'h9B, 1, 8);
        send_frame(1'b0, 8'hC3, 1, 8);
        idle_clear();
        send_frame(1'b0, 8'hE7, 1, 8);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule